// File: doc/BRIEF.md
# Warning Sign Lamp Sequencer

This block is a clocked controller for the lamps of a roadside arrow sign. While an enable switch is held on, it moves through four lamp patterns, one step on every clock. Each pattern lights more lamps than the one before it. After the fullest pattern it returns to dark and starts the sequence again. When the switch is off, the sequence drops back to its dark starting point on the next clock.

Three lamp-group drives leave the block: one for the pair of lamps at the tail of the arrow, one for the middle pair, and one for the single head lamp. The drives depend only on the stored two-bit step. They do not depend on the switch. A divider outside this block sets the clock to a blink rate people can see.

Top module: `signSeq`

## Requirements
- R1: While `rst` is high at a rising edge, the step becomes 0, and all three lamp drives read 0 after that edge.
- R2: The step is a two-bit value. Step 0 means all lamps dark, step 1 lights the tail pair, step 2 lights the tail and middle pairs, and step 3 lights all five lamps.
- R3: With `swOn` high at a rising edge, the step goes from n to n+1. From step 3 it goes back to step 0.
- R4: With `swOn` low at a rising edge, the next step is 0, whatever the current step is.
- R5: `lampTail` is 1 in steps 1, 2 and 3. `lampMid` is 1 in steps 2 and 3. `lampHead` is 1 only in step 3.
- R6: The lamp outputs depend only on the stored step. A change of `swOn` between clock edges does not change them.
- R7: The lamps build up in a fixed order. `lampHead` is never on unless `lampMid` is on, and `lampMid` is never on unless `lampTail` is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous active-high reset |
| swOn | input | 1 | Enable switch; 1 runs the sequence |
| lampTail | output | 1 | Drive for lamps 1 and 2 |
| lampMid | output | 1 | Drive for lamps 3 and 4 |
| lampHead | output | 1 | Drive for lamp 5 |

## Verification
The assertions assume that `swOn` is a clean, synchronous level that is already settled at each rising edge. They predict the next lamp pattern from the value `swOn` had one edge earlier. To stay within that assumption, the bench changes `swOn` only on falling edges. It also toggles `swOn` in the middle of a cycle, between rising edges, and checks that the lamps hold steady (R6). Switch-off is tried at every step of the sequence, including at the wrap, so that the return to step 0 is seen from each state.

// File: rtl/signSeqPkg.sv
package signSeqPkg;
  localparam int STEP_W = 2;
  localparam int NUM_GROUPS = 3;
  typedef logic [STEP_W-1:0] step_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;
    logic advance;
  } ctrl_t;

  // lamp group order in the lamp vector: [0]=tail pair, [1]=middle pair, [2]=head
  localparam int G_TAIL = 0;
  localparam int G_MID  = 1;
  localparam int G_HEAD = 2;
endpackage

// File: rtl/signSeqCtrl.sv
module signSeqCtrl
  import signSeqPkg::*;
(
  input  logic  rst,
  input  logic  swOn,
  output ctrl_t ctrl
);
  always_comb begin
    ctrl.clear   = rst | ~swOn;
    ctrl.advance = ~rst & swOn;
  end
endmodule

// File: rtl/signSeqPath.sv
module signSeqPath
  import signSeqPkg::*;
(
  input  logic                  clk,
  input  ctrl_t                 ctrl,
  output logic [NUM_GROUPS-1:0] lamps
);
  step_t stepQ;

  always_ff @(posedge clk) begin
    if (ctrl.clear)        stepQ <= '0;
    else if (ctrl.advance) stepQ <= stepQ + 1'b1;
  end

  // group g is lit once the step exceeds g (cumulative build-up)
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gLamp
    assign lamps[g] = (stepQ > step_t'(g));
  end
endmodule

// File: rtl/signSeq.sv
module signSeq
  import signSeqPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic swOn,
  output logic lampTail,
  output logic lampMid,
  output logic lampHead
);
  ctrl_t ctrl;
  logic [NUM_GROUPS-1:0] lamps;

  signSeqCtrl u_ctrl (.rst(rst), .swOn(swOn), .ctrl(ctrl));
  signSeqPath u_path (.clk(clk), .ctrl(ctrl), .lamps(lamps));

  assign lampTail = lamps[G_TAIL];
  assign lampMid  = lamps[G_MID];
  assign lampHead = lamps[G_HEAD];
endmodule

// File: rtl/signSeqChk.sv
module signSeqChk (
  input logic clk,
  input logic rst,
  input logic swOn,
  input logic lampTail,
  input logic lampMid,
  input logic lampHead
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  wire [1:0] stepSeen = {lampMid, lampTail ^ lampMid ^ lampHead};

  assert_reset_dark_R1: assert property (@(posedge clk) rst |=> (!lampTail && !lampMid && !lampHead));
  assert_sw_off_clear_R4: assert property (@(posedge clk) disable iff (rst) (seen && !swOn) |=> (!lampTail && !lampMid && !lampHead));
  assert_advance_R3: assert property (@(posedge clk) disable iff (rst) (seen && swOn && !$past(rst)) |=> (stepSeen == 2'($past(stepSeen) + 2'd1)));
  assert_order_R7: assert property (@(posedge clk) disable iff (rst) (seen && !$isunknown(lampHead)) |-> ((!lampHead || lampMid) && (!lampMid || lampTail)));
  assert_head_only_full_R5: assert property (@(posedge clk) disable iff (rst) (seen && swOn && lampHead) |=> (!lampTail && !lampMid));
endmodule

bind signSeq signSeqChk u_chk (.*);

// File: tb/signSeq_tb.sv
module signSeq_tb;
  logic clk = 0, rst = 1, swOn = 0;
  logic lampTail, lampMid, lampHead;
  int errors = 0, checks = 0;
  int expStep = 0;
  typedef struct { logic [2:0] lamps; string req; } item_t;
  item_t q[$];

  signSeq u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [2:0] pat(int s);
    case (s)
      1: return 3'b001;
      2: return 3'b011;
      3: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  // driver: set inputs at negedge, push expectation for after next posedge
  task automatic stepCycle(logic r, logic sw, string req);
    @(negedge clk);
    rst = r; swOn = sw;
    if (r || !sw) expStep = 0; else expStep = (expStep + 1) % 4;
    q.push_back('{pat(expStep), req});
  endtask

  // monitor: compare one cycle later, away from rising edge
  always @(negedge clk) begin
    if (q.size() > 0 && $time > 20) begin
      item_t it;
      logic [2:0] act;
      act = {lampHead, lampMid, lampTail};
      it = q.pop_front();
      checks++;
      if (act !== it.lamps) begin
        errors++;
        $display("FAIL %s: lamps act=%b exp=%b", it.req, act, it.lamps);
      end
    end
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    stepCycle(1, 1, "R1");
    stepCycle(1, 0, "R1");
    for (int i = 0; i < 9; i++) stepCycle(0, 1, "R2_R3_R5");
    // switch off from each step (R4)
    for (int s = 0; s < 4; s++) begin
      while (expStep != s) stepCycle(0, 1, "R3");
      stepCycle(0, 0, "R4");
    end
    // mid-cycle switch glitch (R6)
    stepCycle(0, 1, "R6");
    stepCycle(0, 1, "R6");
    @(posedge clk); #3;
    swOn = 0; #3;
    checks++;
    if ({lampHead, lampMid, lampTail} !== pat(expStep)) begin
      errors++;
      $display("FAIL R6: lamps act=%b exp=%b", {lampHead, lampMid, lampTail}, pat(expStep));
    end
    swOn = 1;
    // R7 ordering across a run, plus reset mid-sequence
    for (int i = 0; i < 3; i++) stepCycle(0, 1, "R7");
    stepCycle(1, 1, "R1");
    stepCycle(0, 1, "R3");
    @(negedge clk); @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule